// File: doc/BRIEF.md
# Hysteretic Temperature Alarm Comparator

This block watches the conversion results of one or more temperature sensor channels. Each new result arrives from the sampler as a one-cycle strobe with a value. For every channel the block runs two hysteretic alarms and one over-temperature trip. The high alarm turns on at a hot trigger level and turns off only after the reading has fallen to a lower release level. The low alarm is its mirror image. Every change of alarm state leaves a sticky event flag: one flag for entering the alarm and one for leaving it. Software clears these flags by writing a one to them.

The over-temperature trip sets its own sticky flag. A 4-bit action key then chooses what the trip does. One key routes the flag into the channel interrupt. Another key issues a one-cycle reset request. Every other key does nothing beyond setting the flag. Results are compared only while the channel is in periodic sampling mode. Bus decoding and register storage are outside this block, so the configuration words enter as ports.

Top module: `thal_top`

## Requirements
- R1: After reset, `stat_o`, `ch_pend_o`, `irq_o` and `rst_req_o` are all zero.
- R2: An alarm config word holds the trigger in bits DW-1:0, the release threshold in bits 2DW-1:DW and the enable in bit 2DW. An enabled, inactive high alarm becomes active on a counted sample that is at or above the trigger, and sets status bit 0 at the clock edge that takes the strobe.
- R3: An active high alarm becomes inactive on a counted sample that is at or below its release threshold, and sets status bit 1. Samples that keep the state unchanged raise no event.
- R4: The low alarm uses status bit 2 for entry (sample at or below its trigger) and status bit 3 for exit (sample at or above its release threshold).
- R5: The over-temperature word holds the threshold in bits DW-1:0 and the enable in bit DW. Each counted sample at or above the threshold sets status bit 4.
- R6: The action key is `int_ctl` bits 7:4. Key 0x5 makes status bit 4 count toward the channel pending flag. Key 0xA makes `rst_req_o` high for the one cycle after each trip. Any other key does neither.
- R7: A strobe counts only while that channel's `periodic_i` is high. When it is low, the strobe changes no state and no flag.
- R8: Status flags stay set until a one is written to the matching `stat_clr_i` bit. If a flag is set and cleared in the same cycle, the set wins.
- R9: `int_ctl` bits 3:0 enable status bits 3:0. `ch_pend_o[n]` is the OR of channel n's enabled status flags. `irq_o` is the OR of the pending flags whose `ch_ie_i` bit is set.
- R10: Clearing an alarm's enable drops its active state and raises no event. When the alarm is enabled again, a sample at its trigger counts as a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periodic_i | input | NCH | Per-channel periodic mode; comparisons run only when high |
| smp_stb_i | input | NCH | Per-channel new-sample strobe |
| smp_data_i | input | NCH*DW | Per-channel sample value |
| hi_cfg_i | input | NCH*(2*DW+1) | High alarm {enable, release, trigger} per channel |
| lo_cfg_i | input | NCH*(2*DW+1) | Low alarm {enable, release, trigger} per channel |
| ot_cfg_i | input | NCH*(DW+1) | Over-temperature {enable, threshold} per channel |
| int_ctl_i | input | NCH*8 | Per channel: [7:4] action key, [3:0] alarm event enables |
| stat_clr_i | input | NCH*5 | Write-one-to-clear strobes for the status flags |
| ch_ie_i | input | NCH | Per-channel interrupt enable |
| stat_o | output | NCH*5 | Sticky status flags per channel |
| ch_pend_o | output | NCH | Per-channel pending flag |
| irq_o | output | 1 | Combined interrupt request |
| rst_req_o | output | 1 | One-cycle reset request from an over-temperature trip |

## Verification
The bench aims samples at the trigger and release levels exactly and one count either side of them. An off-by-one comparison would miss the edge value or flag the value next to it. It also sends strobes with periodic mode off, which a design that ignored the mode would count as alarms. Other directed cases clear a flag in the same cycle it is set, which would lose an event if the clear won. A further case disables an alarm while it is active, which a design that kept the state would later report as a bogus exit. The action keys 0x5, 0xA and a third value are all exercised. Mixing up the keys would route the trip to the wrong output or act on an unknown key.

// File: rtl/thal_pkg.sv
package thal_pkg;
   typedef enum logic {
      DIR_HIGH = 1'b0,
      DIR_LOW  = 1'b1
   } thal_dir_e;

   localparam int unsigned NFLAG    = 5;
   localparam int unsigned F_HI_ENT = 0;
   localparam int unsigned F_HI_LVE = 1;
   localparam int unsigned F_LO_ENT = 2;
   localparam int unsigned F_LO_LVE = 3;
   localparam int unsigned F_OT     = 4;

   localparam logic [3:0] OT_KEY_IRQ = 4'h5;
   localparam logic [3:0] OT_KEY_RST = 4'hA;
endpackage

// File: rtl/thal_hyst.sv
module thal_hyst
   import thal_pkg::*;
#(
   parameter int unsigned DW  = 12,
   parameter thal_dir_e   DIR = DIR_HIGH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          upd_i,
   input  logic [DW-1:0] smp_i,
   input  logic [DW-1:0] trig_i,
   input  logic [DW-1:0] rel_i,
   output logic          enter_o,
   output logic          leave_o
);
   logic act_q;
   logic hit, back;

   generate
      if (DIR == DIR_HIGH) begin : g_high
         assign hit  = (smp_i >= trig_i);
         assign back = (smp_i <= rel_i);
      end else begin : g_low
         assign hit  = (smp_i <= trig_i);
         assign back = (smp_i >= rel_i);
      end
   endgenerate

   assign enter_o = upd_i & en_i & ~act_q & hit;
   assign leave_o = upd_i & en_i &  act_q & back;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= 1'b0;
      else if (!en_i)   act_q <= 1'b0;
      else if (enter_o) act_q <= 1'b1;
      else if (leave_o) act_q <= 1'b0;
   end

   assert_rise_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(upd_i && en_i));
   assert_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_q) |-> $past(leave_o || !en_i));
endmodule

// File: rtl/thal_ot.sv
module thal_ot
   import thal_pkg::*;
#(
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          upd_i,
   input  logic [DW-1:0] smp_i,
   input  logic [DW-1:0] thr_i,
   input  logic [3:0]    key_i,
   output logic          trip_o,
   output logic          irq_sel_o,
   output logic          rst_o
);
   logic rst_q;

   assign trip_o    = upd_i & en_i & (smp_i >= thr_i);
   assign irq_sel_o = (key_i == OT_KEY_IRQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= trip_o & (key_i == OT_KEY_RST);
   end
   assign rst_o = rst_q;

   assert_rst_needs_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> $past(trip_o && key_i == OT_KEY_RST));
endmodule

// File: rtl/thal_chan.sv
module thal_chan
   import thal_pkg::*;
#(
   parameter int unsigned DW = 12,
   localparam int unsigned AW = 2 * DW + 1,
   localparam int unsigned OW = DW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             periodic_i,
   input  logic             stb_i,
   input  logic [DW-1:0]    smp_i,
   input  logic [AW-1:0]    hi_cfg_i,
   input  logic [AW-1:0]    lo_cfg_i,
   input  logic [OW-1:0]    ot_cfg_i,
   input  logic [7:0]       ictl_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] stat_o,
   output logic             pend_o,
   output logic             rst_o
);
   logic             upd;
   logic [NFLAG-1:0] set, flags_q, mask;
   logic             ot_trip, ot_irq;

   assign upd = stb_i & periodic_i;

   thal_hyst #(.DW(DW), .DIR(DIR_HIGH)) u_hi (
      .clk(clk), .rst_n(rst_n), .en_i(hi_cfg_i[2*DW]), .upd_i(upd), .smp_i(smp_i),
      .trig_i(hi_cfg_i[DW-1:0]), .rel_i(hi_cfg_i[2*DW-1:DW]),
      .enter_o(set[F_HI_ENT]), .leave_o(set[F_HI_LVE]));

   thal_hyst #(.DW(DW), .DIR(DIR_LOW)) u_lo (
      .clk(clk), .rst_n(rst_n), .en_i(lo_cfg_i[2*DW]), .upd_i(upd), .smp_i(smp_i),
      .trig_i(lo_cfg_i[DW-1:0]), .rel_i(lo_cfg_i[2*DW-1:DW]),
      .enter_o(set[F_LO_ENT]), .leave_o(set[F_LO_LVE]));

   thal_ot #(.DW(DW)) u_ot (
      .clk(clk), .rst_n(rst_n), .en_i(ot_cfg_i[DW]), .upd_i(upd), .smp_i(smp_i),
      .thr_i(ot_cfg_i[DW-1:0]), .key_i(ictl_i[7:4]),
      .trip_o(ot_trip), .irq_sel_o(ot_irq), .rst_o(rst_o));

   assign set[F_OT] = ot_trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set;
   end

   assign mask   = {ot_irq, ictl_i[3:0]};
   assign stat_o = flags_q;
   assign pend_o = |(flags_q & mask);

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_chk
         assert_flag_from_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[i]) |-> $past(stb_i && periodic_i));
         assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[i] && !clr_i[i] |=> flags_q[i]);
      end
   endgenerate
endmodule

// File: rtl/thal_top.sv
module thal_top
   import thal_pkg::*;
#(
   parameter int unsigned NCH = 2,
   parameter int unsigned DW  = 12,
   localparam int unsigned AW = 2 * DW + 1,
   localparam int unsigned OW = DW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH-1:0]       periodic_i,
   input  logic [NCH-1:0]       smp_stb_i,
   input  logic [NCH*DW-1:0]    smp_data_i,
   input  logic [NCH*AW-1:0]    hi_cfg_i,
   input  logic [NCH*AW-1:0]    lo_cfg_i,
   input  logic [NCH*OW-1:0]    ot_cfg_i,
   input  logic [NCH*8-1:0]     int_ctl_i,
   input  logic [NCH*NFLAG-1:0] stat_clr_i,
   input  logic [NCH-1:0]       ch_ie_i,
   output logic [NCH*NFLAG-1:0] stat_o,
   output logic [NCH-1:0]       ch_pend_o,
   output logic                 irq_o,
   output logic                 rst_req_o
);
   logic [NCH-1:0] ch_rst;

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("thal_top: NCH out of range");
      end
      if (DW < 2 || DW > 24) begin : g_bad_dw
         $error("thal_top: DW out of range");
      end
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         thal_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .periodic_i(periodic_i[c]), .stb_i(smp_stb_i[c]),
            .smp_i(smp_data_i[c*DW +: DW]),
            .hi_cfg_i(hi_cfg_i[c*AW +: AW]), .lo_cfg_i(lo_cfg_i[c*AW +: AW]),
            .ot_cfg_i(ot_cfg_i[c*OW +: OW]), .ictl_i(int_ctl_i[c*8 +: 8]),
            .clr_i(stat_clr_i[c*NFLAG +: NFLAG]), .stat_o(stat_o[c*NFLAG +: NFLAG]),
            .pend_o(ch_pend_o[c]), .rst_o(ch_rst[c]));
      end
   endgenerate

   assign irq_o     = |(ch_pend_o & ch_ie_i);
   assign rst_req_o = |ch_rst;

   assert_rst_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(|(periodic_i & smp_stb_i)));
   assert_irq_has_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ch_pend_o != '0));
endmodule

// File: tb/thal_top_tb_top.sv
module thal_top_tb_top;
   localparam int NCH = 2;
   localparam int DW  = 12;
   localparam int AW  = 2 * DW + 1;
   localparam int OW  = DW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          per  [NCH];
   logic          stb  [NCH];
   logic [DW-1:0] dat  [NCH];
   logic [AW-1:0] hcfg [NCH];
   logic [AW-1:0] lcfg [NCH];
   logic [OW-1:0] ocfg [NCH];
   logic [7:0]    ictl [NCH];
   logic [4:0]    clr  [NCH];
   logic          ie   [NCH];

   logic [NCH-1:0] periodic_i, smp_stb_i, ch_ie_i, ch_pend_o;
   logic [NCH*DW-1:0] smp_data_i;
   logic [NCH*AW-1:0] hi_cfg_i, lo_cfg_i;
   logic [NCH*OW-1:0] ot_cfg_i;
   logic [NCH*8-1:0]  int_ctl_i;
   logic [NCH*5-1:0]  stat_clr_i, stat_o;
   logic irq_o, rst_req_o;

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         periodic_i[c] = per[c];
         smp_stb_i[c]  = stb[c];
         ch_ie_i[c]    = ie[c];
         smp_data_i[c*DW +: DW] = dat[c];
         hi_cfg_i[c*AW +: AW]   = hcfg[c];
         lo_cfg_i[c*AW +: AW]   = lcfg[c];
         ot_cfg_i[c*OW +: OW]   = ocfg[c];
         int_ctl_i[c*8 +: 8]    = ictl[c];
         stat_clr_i[c*5 +: 5]   = clr[c];
      end
   end

   thal_top #(.NCH(NCH), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .periodic_i(periodic_i), .smp_stb_i(smp_stb_i),
      .smp_data_i(smp_data_i), .hi_cfg_i(hi_cfg_i), .lo_cfg_i(lo_cfg_i),
      .ot_cfg_i(ot_cfg_i), .int_ctl_i(int_ctl_i), .stat_clr_i(stat_clr_i),
      .ch_ie_i(ch_ie_i), .stat_o(stat_o), .ch_pend_o(ch_pend_o),
      .irq_o(irq_o), .rst_req_o(rst_req_o));

   int checks = 0;
   int errors = 0;

   logic       m_ahi [NCH];
   logic       m_alo [NCH];
   logic [4:0] m_flg [NCH];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] acfg(input logic en, input int rel, input int trig);
      return {en, rel[DW-1:0], trig[DW-1:0]};
   endfunction

   // next state of one hysteretic alarm; returns {active, leave, enter}
   function automatic logic [2:0] alarm_next(input logic low, input logic act, input logic upd,
                                             input logic [AW-1:0] cfg, input logic [DW-1:0] d);
      logic en, hit, back, ent, lve;
      en   = cfg[2*DW];
      hit  = low ? (d <= cfg[DW-1:0])    : (d >= cfg[DW-1:0]);
      back = low ? (d >= cfg[2*DW-1:DW]) : (d <= cfg[2*DW-1:DW]);
      ent  = upd & en & ~act & hit;
      lve  = upd & en & act & back;
      return {(!en) ? 1'b0 : (ent ? 1'b1 : (lve ? 1'b0 : act)), lve, ent};
   endfunction

   task automatic cycle(input string tag);
      logic rst_exp;
      logic [NCH-1:0] pend_exp;
      logic irq_exp;
      rst_exp = 1'b0;
      irq_exp = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         logic upd, trip;
         logic [2:0] h, l;
         logic [4:0] set, mask;
         upd  = stb[c] & per[c];
         h    = alarm_next(1'b0, m_ahi[c], upd, hcfg[c], dat[c]);
         l    = alarm_next(1'b1, m_alo[c], upd, lcfg[c], dat[c]);
         trip = upd & ocfg[c][DW] & (dat[c] >= ocfg[c][DW-1:0]);
         set  = {trip, l[1], l[0], h[1], h[0]};
         m_ahi[c] = h[2];
         m_alo[c] = l[2];
         m_flg[c] = (m_flg[c] & ~clr[c]) | set;
         if (trip && ictl[c][7:4] == 4'hA) rst_exp = 1'b1;
         mask = {ictl[c][7:4] == 4'h5, ictl[c][3:0]};
         pend_exp[c] = |(m_flg[c] & mask);
         if (pend_exp[c] && ie[c]) irq_exp = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
         check({tag, " R2 R3 R4 R5 status"}, 32'(stat_o[c*5 +: 5]), 32'(m_flg[c]));
      check({tag, " R9 pend"}, 32'(ch_pend_o), 32'(pend_exp));
      check({tag, " R9 irq"}, 32'(irq_o), 32'(irq_exp));
      check({tag, " R6 rst_req"}, 32'(rst_req_o), 32'(rst_exp));
      for (int c = 0; c < NCH; c++) begin
         stb[c] = 1'b0;
         clr[c] = '0;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_7a11));
      for (int c = 0; c < NCH; c++) begin
         per[c] = 1'b1; stb[c] = 1'b0; dat[c] = '0; ie[c] = 1'b1;
         hcfg[c] = acfg(1'b1, 2997, 3000);
         lcfg[c] = acfg(1'b1, 503, 500);
         ocfg[c] = {1'b1, 12'd3500};
         ictl[c] = 8'h5F; clr[c] = '0;
         m_ahi[c] = 1'b0; m_alo[c] = 1'b0; m_flg[c] = '0;
      end
      repeat (3) @(negedge clk);
      check("R1 reset stat", 32'(stat_o), 32'h0);
      check("R1 reset pend", 32'(ch_pend_o), 32'h0);
      check("R1 reset irq", 32'(irq_o), 32'h0);
      check("R1 reset rst_req", 32'(rst_req_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 32'(stat_o), 32'h0);

      // R2 one below trigger, then exactly at trigger
      dat[0] = 12'd2999; stb[0] = 1'b1; cycle("R2 below trig");
      dat[0] = 12'd3000; stb[0] = 1'b1; cycle("R2 at trig");
      // R3 still active: no new events
      dat[0] = 12'd2998; stb[0] = 1'b1; clr[0] = 5'h1F; cycle("R3 clear all");
      dat[0] = 12'd3100; stb[0] = 1'b1; cycle("R3 no re-entry");
      dat[0] = 12'd2997; stb[0] = 1'b1; cycle("R3 at release");
      // R4 low alarm edges
      dat[1] = 12'd501; stb[1] = 1'b1; cycle("R4 above low trig");
      dat[1] = 12'd500; stb[1] = 1'b1; cycle("R4 at low trig");
      dat[1] = 12'd502; stb[1] = 1'b1; cycle("R4 below release");
      dat[1] = 12'd503; stb[1] = 1'b1; cycle("R4 at release");
      // R7 non-periodic strobes ignored
      clr[0] = 5'h1F; clr[1] = 5'h1F; cycle("R8 clear");
      per[0] = 1'b0; dat[0] = 12'd4000; stb[0] = 1'b1; cycle("R7 ignored");
      dat[0] = 12'd10; stb[0] = 1'b1; cycle("R7 ignored low");
      per[0] = 1'b1;
      // R8 set wins over clear
      dat[0] = 12'd3000; stb[0] = 1'b1; clr[0] = 5'h01; cycle("R8 set beats clear");
      // R10 disable while active, then re-enable
      hcfg[0] = acfg(1'b0, 2997, 3000); dat[0] = 12'd100; stb[0] = 1'b1; cycle("R10 disable");
      hcfg[0] = acfg(1'b1, 2997, 3000); clr[0] = 5'h1F; cycle("R10 re-enable");
      dat[0] = 12'd3000; stb[0] = 1'b1; cycle("R10 fresh entry");
      // R5/R6 over-temperature keys
      ictl[0] = 8'hA0; dat[0] = 12'd3500; stb[0] = 1'b1; clr[0] = 5'h1F; cycle("R6 key rst");
      cycle("R6 rst one cycle");
      ictl[0] = 8'h50; dat[0] = 12'd3499; stb[0] = 1'b1; cycle("R5 below ot");
      dat[0] = 12'd3600; stb[0] = 1'b1; cycle("R6 key irq");
      ictl[0] = 8'h30; clr[0] = 5'h1F; cycle("R8 clr");
      dat[0] = 12'd3900; stb[0] = 1'b1; cycle("R6 other key");
      ie[0] = 1'b0; ictl[0] = 8'h5F; cycle("R9 ie off");
      ie[0] = 1'b1;

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         if (n % 64 == 0) begin
            for (int c = 0; c < NCH; c++) begin
               int ht, lt;
               ht = $urandom_range(2000, 3800);
               lt = $urandom_range(200, 1500);
               hcfg[c] = acfg($urandom_range(0, 7) != 0, ht - $urandom_range(0, 6), ht);
               lcfg[c] = acfg($urandom_range(0, 7) != 0, lt + $urandom_range(0, 6), lt);
               ocfg[c] = {1'b1, 12'(ht + $urandom_range(0, 200))};
               case ($urandom_range(0, 2))
                  0: ictl[c] = {4'h5, 4'($urandom)};
                  1: ictl[c] = {4'hA, 4'($urandom)};
                  default: ictl[c] = 8'($urandom);
               endcase
               ie[c] = $urandom_range(0, 1);
            end
         end
         for (int c = 0; c < NCH; c++) begin
            per[c] = ($urandom_range(0, 9) != 0);
            stb[c] = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
               0: dat[c] = hcfg[c][DW-1:0] + 12'($urandom_range(0, 6)) - 12'd3;
               1: dat[c] = lcfg[c][DW-1:0] + 12'($urandom_range(0, 6)) - 12'd3;
               2: dat[c] = ocfg[c][DW-1:0] + 12'($urandom_range(0, 4)) - 12'd2;
               default: dat[c] = 12'($urandom);
            endcase
         end
         cycle("rand");
         for (int c = 0; c < NCH; c++)
            if ($urandom_range(0, 5) == 0) clr[c] = 5'($urandom);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule